// File: doc/BRIEF.md
# Serial Audio Input Receiver

This block turns a three-wire serial audio stream into parallel stereo samples. The three wires are a bit clock, a channel-select clock and a data line. It samples all three in one system-clock domain. The two clocks are first resynchronised, and rising edges of the bit clock are found there. For this to work, the system clock must run at four or more times the bit-clock rate.

Three framings are supported, chosen by static configuration inputs:

- **Right-justified, 16-bit.** Data is MSB first, and the LSB arrives just before the channel-select transition.
- **Right-justified, 20-bit.** The same framing with 20 data bits.
- **I2S-style, 16-bit.** Each channel word lasts 32 bit clocks, and the data starts one bit clock after the channel-select transition.

The block always presents 20-bit samples. A 16-bit sample is left-aligned and zero-padded below its LSB. A third configuration input swaps which channel-select level means left. After a left sample and then a right sample have both been captured, the pair is presented on the outputs with a one-cycle strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: In either right-justified format, the captured word is the last N data bits sampled on bit-clock rising edges before the rising edge at which a new channel-select level is seen, MSB first. Any extra bit clocks earlier in that word are ignored.
- R2: With `cfg_wide`=1 and `cfg_i2s`=0, all 20 captured bits appear on the sample output, MSB at bit 19.
- R3: In any 16-bit mode, the 16 data bits appear on output bits [19:4], and bits [3:0] are zero.
- R4: With `cfg_i2s`=1, the bit sampled on the rising edge where the new channel-select level is first seen is skipped. The next 16 bits form the word, MSB first. Any remaining bit clocks of the 32-clock word are ignored.
- R5: With `cfg_i2s`=1, the block behaves as 16-bit whatever the value of `cfg_wide`.
- R6: With `cfg_ws_swap`=0, channel-select high marks the left word. With `cfg_ws_swap`=1, channel-select low marks the left word. The same mapping applies in every format.
- R7: `frame_valid` is a one-cycle pulse, raised only when a right word is captured after a left word. At that pulse, `left_sample` and `right_sample` carry that pair. A right word with no pending left word produces no pulse.
- R8: `left_sample` and `right_sample` do not change in any cycle without `frame_valid`.
- R9: While `rst` is high, both samples are zero and `frame_valid` is low. The first bit-clock rising edge after reset only records the channel-select level and captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 selects 20-bit resolution; 0 selects 16-bit |
| cfg_i2s | input | 1 | 1 selects the I2S-style 32-clock framing |
| cfg_ws_swap | input | 1 | 1 makes channel-select low the left channel |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| ws_in | input | 1 | Channel-select clock, asynchronous |
| sdata_in | input | 1 | Serial data line, asynchronous |
| left_sample | output | 20 | Left sample of the latest frame |
| right_sample | output | 20 | Right sample of the latest frame |
| frame_valid | output | 1 | One-cycle strobe when a new stereo pair is presented |

## Verification
Some properties are checked on every cycle by assertions:

- `frame_valid` is a single-cycle pulse.
- Both samples hold steady between strobes.
- The four pad bits are zero whenever a 16-bit mode presents a frame.
- Every internal capture follows a detected bit-clock rising edge.

Other properties can only be shown by the bench scenarios, which compare each strobe against a behavioural model of the bit stream. These include which bits form each word, the skipped delay slot, the polarity swap and the dropping of a lone right word.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    FMT_RJ_NARROW = 2'd0,
    FMT_RJ_WIDE   = 2'd1,
    FMT_I2S       = 2'd2
  } fmt_e;

  // The I2S-style framing only carries narrow words, so the wide flag is
  // discarded whenever it is selected.
  function automatic fmt_e pick_fmt(input logic i2s, input logic wide);
    if (i2s)  return FMT_I2S;
    if (wide) return FMT_RJ_WIDE;
    return FMT_RJ_NARROW;
  endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sar_edge.sv
module sar_edge (
  input  logic clk,
  input  logic rst,
  input  logic bclk_s,
  input  logic ws_s,
  input  logic sd_s,
  output logic rise_o,
  output logic ws_o,
  output logic bit_o
);

  logic bclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
      rise_o <= 1'b0;
      ws_o   <= 1'b0;
      bit_o  <= 1'b0;
    end else begin
      bclk_q <= bclk_s;
      rise_o <= bclk_s & ~bclk_q;
      ws_o   <= ws_s;
      bit_o  <= sd_s;
    end
  end

endmodule

// File: rtl/sar_deser.sv
module sar_deser
  import sar_pkg::*;
#(
  parameter int SMP_W    = 20,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  fmt_e             fmt,
  input  logic             ws_swap,
  input  logic             rise,
  input  logic             ws,
  input  logic             din,
  output logic             cap_stb,
  output logic             cap_left,
  output logic [SMP_W-1:0] cap_word
);

  localparam int PAD_W = SMP_W - NARROW_W;
  localparam int CNT_W = $clog2(NARROW_W + 2);
  localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(NARROW_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NARROW_W);
  localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(1);

  logic             primed;
  logic             ws_prev;
  logic [SMP_W-1:0] sr;
  logic [CNT_W-1:0] cnt;
  logic             ws_edge;

  assign ws_edge = rise & primed & (ws != ws_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      primed   <= 1'b0;
      ws_prev  <= 1'b0;
      sr       <= '0;
      cnt      <= CNT_IDLE;
      cap_stb  <= 1'b0;
      cap_left <= 1'b0;
      cap_word <= '0;
    end else begin
      cap_stb <= 1'b0;
      if (rise) begin
        primed  <= 1'b1;
        ws_prev <= ws;
        if (fmt == FMT_I2S) begin
          if (ws_edge) begin
            cnt <= CNT_FIRST;
          end else if (cnt != CNT_IDLE) begin
            sr  <= {sr[SMP_W-2:0], din};
            cnt <= cnt + CNT_FIRST;
            if (cnt == CNT_LAST) begin
              cap_stb  <= 1'b1;
              cap_left <= ws ^ ws_swap;
              cap_word <= {sr[NARROW_W-2:0], din, {PAD_W{1'b0}}};
            end
          end
        end else begin
          sr <= {sr[SMP_W-2:0], din};
          if (ws_edge) begin
            cap_stb  <= 1'b1;
            cap_left <= ws_prev ^ ws_swap;
            cap_word <= (fmt == FMT_RJ_WIDE) ? sr
                                             : {sr[NARROW_W-1:0], {PAD_W{1'b0}}};
          end
        end
      end
    end
  end

  // R1
  cap_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    cap_stb |-> $past(rise));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int SMP_W       = 20,
  parameter int NARROW_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wide,
  input  logic             cfg_i2s,
  input  logic             cfg_ws_swap,
  input  logic             bclk_in,
  input  logic             ws_in,
  input  logic             sdata_in,
  output logic [SMP_W-1:0] left_sample,
  output logic [SMP_W-1:0] right_sample,
  output logic             frame_valid
);

  localparam int PAD_W = SMP_W - NARROW_W;

  fmt_e             fmt;
  logic [2:0]       raw_in;
  logic [2:0]       sync_q;
  logic             rise, ws_b, bit_b;
  logic             cap_stb, cap_left;
  logic [SMP_W-1:0] cap_word;
  logic             have_l;
  logic [SMP_W-1:0] hold_l;

  assign fmt    = pick_fmt(cfg_i2s, cfg_wide);
  assign raw_in = {bclk_in, ws_in, sdata_in};

  sar_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (raw_in), .q (sync_q)
  );

  sar_edge u_edge (
    .clk (clk), .rst (rst),
    .bclk_s (sync_q[2]), .ws_s (sync_q[1]), .sd_s (sync_q[0]),
    .rise_o (rise), .ws_o (ws_b), .bit_o (bit_b)
  );

  sar_deser #(.SMP_W(SMP_W), .NARROW_W(NARROW_W)) u_deser (
    .clk (clk), .rst (rst), .fmt (fmt), .ws_swap (cfg_ws_swap),
    .rise (rise), .ws (ws_b), .din (bit_b),
    .cap_stb (cap_stb), .cap_left (cap_left), .cap_word (cap_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      have_l       <= 1'b0;
      hold_l       <= '0;
      left_sample  <= '0;
      right_sample <= '0;
      frame_valid  <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (cap_stb) begin
        if (cap_left) begin
          hold_l <= cap_word;
          have_l <= 1'b1;
        end else if (have_l) begin
          left_sample  <= hold_l;
          right_sample <= cap_word;
          frame_valid  <= 1'b1;
          have_l       <= 1'b0;
        end
      end
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  // R8
  sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> ($stable(left_sample) && $stable(right_sample)));

  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && fmt != FMT_RJ_WIDE) |->
      (left_sample[PAD_W-1:0] == '0 && right_sample[PAD_W-1:0] == '0));

endmodule

// File: tb/serial_audio_rx_bench.sv
`timescale 1ns/1ps
module serial_audio_rx_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wide = 1'b0, cfg_i2s = 1'b0, cfg_ws_swap = 1'b0;
  logic        bclk_in = 1'b0, ws_in = 1'b0, sdata_in = 1'b0;
  logic [19:0] left_sample, right_sample;
  logic        frame_valid;

  always #2.5 clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .clk (clk), .rst (rst),
    .cfg_wide (cfg_wide), .cfg_i2s (cfg_i2s), .cfg_ws_swap (cfg_ws_swap),
    .bclk_in (bclk_in), .ws_in (ws_in), .sdata_in (sdata_in),
    .left_sample (left_sample), .right_sample (right_sample),
    .frame_valid (frame_valid)
  );

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  logic [19:0] q_l[$];
  logic [19:0] q_r[$];
  string       q_t[$];
  logic [19:0] last_l = '0, last_r = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [19:0] narrow(input logic [19:0] v);
    return {v[15:0], 4'h0};
  endfunction

  // Reference comparison on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (frame_valid) begin
        if (q_l.size() == 0) begin
          chk(1'b0, "R7", "unexpected frame strobe", left_sample, '0);
        end else begin
          string t;
          logic [19:0] el, er;
          el = q_l.pop_front(); er = q_r.pop_front(); t = q_t.pop_front();
          chk(left_sample == el, t, "left sample", left_sample, el);
          chk(right_sample == er, t, "right sample", right_sample, er);
        end
        last_l = left_sample;
        last_r = right_sample;
      end else begin
        // R8
        chk(left_sample == last_l && right_sample == last_r, "R8",
            "samples changed without strobe", left_sample, last_l);
      end
    end
  end

  task automatic sbit(input logic w, input logic d);
    bclk_in = 1'b0; ws_in = w; sdata_in = d;
    repeat (4) @(negedge clk);
    bclk_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset(input logic wide, input logic i2s, input logic swap);
    rst = 1'b1;
    bclk_in = 1'b0; ws_in = 1'b0; sdata_in = 1'b0;
    cfg_wide = wide; cfg_i2s = i2s; cfg_ws_swap = swap;
    repeat (4) @(negedge clk);
    // R9
    chk(left_sample == '0 && right_sample == '0, "R9", "samples in reset",
        left_sample | right_sample, '0);
    chk(!frame_valid, "R9", "strobe in reset", {19'd0, frame_valid}, '0);
    last_l = '0; last_r = '0;
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rj_group(input logic wide, input logic swap, input int pad,
                          input string tag);
    logic lvl;
    lvl = ~swap;
    do_reset(wide, 1'b0, swap);
    sbit(~lvl, 1'b1);                       // R9 priming bit; lone right word dropped (R7)
    for (int f = 0; f < 3; f++) begin
      logic [19:0] l, r;
      l = 20'hA5F3C ^ (20'h13579 * f);
      r = 20'h5C3A1 + (20'h0F0F1 * f);
      q_l.push_back(wide ? l : narrow(l));
      q_r.push_back(wide ? r : narrow(r));
      q_t.push_back(tag);
      for (int i = 0; i < pad; i++) sbit(lvl, i[0]);
      for (int i = (wide ? 19 : 15); i >= 0; i--) sbit(lvl, l[i]);
      for (int i = 0; i < pad; i++) sbit(~lvl, ~i[0]);
      for (int i = (wide ? 19 : 15); i >= 0; i--) sbit(~lvl, r[i]);
    end
    sbit(lvl, 1'b0);
    repeat (12) @(negedge clk);
  endtask

  task automatic i2s_group(input logic wide, input logic swap, input string tag);
    logic lvl;
    lvl = ~swap;
    do_reset(wide, 1'b1, swap);
    sbit(~lvl, 1'b0);
    for (int f = 0; f < 3; f++) begin
      logic [19:0] l, r;
      l = 20'h3C96E ^ (20'h24681 * f);
      r = 20'hC1D2B + (20'h11111 * f);
      q_l.push_back(narrow(l));
      q_r.push_back(narrow(r));
      q_t.push_back(tag);
      sbit(lvl, ~l[15]);                    // R4 delay slot
      for (int i = 15; i >= 0; i--) sbit(lvl, l[i]);
      for (int i = 0; i < 15; i++) sbit(lvl, i[0]);
      sbit(~lvl, ~r[15]);
      for (int i = 15; i >= 0; i--) sbit(~lvl, r[i]);
      for (int i = 0; i < 15; i++) sbit(~lvl, ~i[0]);
    end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    rj_group(1'b0, 1'b0, 0, "R3");   // 16-bit right-justified
    rj_group(1'b0, 1'b0, 3, "R1");   // leading extra bits ignored
    rj_group(1'b1, 1'b0, 0, "R2");   // 20-bit
    rj_group(1'b1, 1'b0, 4, "R1");
    rj_group(1'b0, 1'b1, 2, "R6");   // swapped polarity
    i2s_group(1'b0, 1'b0, "R4");
    i2s_group(1'b1, 1'b1, "R5");     // wide ignored, swapped polarity
    done = 1'b1;
    // R7
    chk(q_l.size() == 0, "R7", "frames never presented",
        20'(q_l.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog expired: actual %h expected %h", 20'd0, 20'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule